// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Period End

This block is a 16-bit up-counting timer that produces single-slope pulse-width modulation on a set of compare channels. The counter climbs from zero to a period end value (TOP) and returns to zero on the next timer tick. A mode field picks where TOP comes from. It can be one of three fixed values, a period register that takes effect at once, or the active value of compare channel 0, which is double buffered. Each channel compares the count with its own active compare value and drives one output pin. The pin can be off, follow the waveform, or show its complement.

Software programs the block through a simple write port. A control register holds the mode and the per-channel output modes. A period register feeds TOP in one mode. Compare writes go into per-channel buffers. A flag address takes write-one-to-clear masks. The timer advances only on cycles where the tick input is high, so an external prescaler sets the count rate. Three kinds of sticky flags record the period end, the period-register match, and the per-channel compare matches.

Top module: `fast_pwm_timer`

## Requirements
- R1: Control bits [3:0] select the mode. Value 5 gives TOP = 0x00FF, 6 gives 0x01FF and 7 gives 0x03FF.
- R2: The count changes only on a clock edge where `tick` is high and the mode is supported. On such an edge, a count equal to TOP becomes 0. Any other count becomes count+1, and 0xFFFF becomes 0x0000.
- R3: On the edge where the count leaves TOP, `ovf_flag` sets. In mode 14 `cap_flag` sets on the same edge. In mode 15 `cmp_flag[0]` sets on the same edge.
- R4: `cmp_flag[i]` sets on a counting edge where the count equals channel i's active compare value.
- R5: Flags stay set until a write to address 2 with a one in the flag's bit: bit 0 clears `ovf_flag`, bit 1 clears `cap_flag`, bit 2+i clears `cmp_flag[i]`.
- R6: A write to address 4+i fills channel i's buffer only. The active compare value takes the buffer contents on the edge where the count leaves TOP.
- R7: In mode 15, TOP is channel 0's active compare value, so a new buffered TOP applies from the next period.
- R8: In mode 14, TOP is the period register (address 1) as soon as it is written. If the new value is below the count, the count runs up to 0xFFFF, wraps to 0 and ends the period at the new value.
- R9: While mode 5, 6 or 7 is active, compare writes are ANDed with that mode's fixed TOP.
- R10: Output mode field i is control bits [5+2i:4+2i]. Mode 2 drives the pin high from the period-end edge until the edge after the count equals the compare value; the period end wins a tie. Mode 3 drives the complement. Modes 0 and 1 drive the pin low.
- R11: If a channel's active compare value is above TOP, a period with the count kept at or below TOP sets no flag for that channel, and a mode-2 pin stays high.
- R12: In modes other than 5, 6, 7, 14 and 15, the count holds and no flag sets.
- R13: Reset (`rst_n` low) clears the count, the control, period and compare registers, the buffers, the flags and the pin states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Timer-clock enable; the count advances only when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: 0 control, 1 period, 2 flag clear, 4+i compare buffer i |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Current count |
| pwm_o | output | NCH (3) | Channel output pins |
| ovf_flag | output | 1 | Sticky period-end flag |
| cap_flag | output | 1 | Sticky period-register match flag (mode 14) |
| cmp_flag | output | NCH (3) | Sticky compare-match flags |

## Verification
A wrong TOP selection shows on `cnt_o` within one period: the count either returns to zero too early or passes the expected end. A buffer that is copied too early or too late moves the falling edge of the channel pin by a whole period, or leaves it in the wrong period. Stale masking shows as a pin that never falls. A corrupted flag or pin state appears on the ports one cycle after the counting edge that caused it. The full-range wrap after a low period write takes one pass of 65536 ticks to show.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the single-slope PWM timer.
// Assumes a 4-bit write address and a 4-bit mode field.
package tmr_pkg;

    localparam int ADDR_W = 4;
    localparam int MODE_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_PERIOD   = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_FLAGCLR  = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_CMP_BASE = 4'd4;

    localparam logic [MODE_W-1:0] MODE_TOP8   = 4'd5;
    localparam logic [MODE_W-1:0] MODE_TOP9   = 4'd6;
    localparam logic [MODE_W-1:0] MODE_TOP10  = 4'd7;
    localparam logic [MODE_W-1:0] MODE_PERIOD = 4'd14;
    localparam logic [MODE_W-1:0] MODE_CMPA   = 4'd15;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'd0,
        OUT_RSVD   = 2'd1,
        OUT_NONINV = 2'd2,
        OUT_INV    = 2'd3
    } out_mode_e;

    // True for the three fixed-period modes.
    function automatic logic mode_fixed(input logic [MODE_W-1:0] m);
        return (m == MODE_TOP8) || (m == MODE_TOP9) || (m == MODE_TOP10);
    endfunction

    // True for every mode this block counts in.
    function automatic logic mode_runs(input logic [MODE_W-1:0] m);
        return mode_fixed(m) || (m == MODE_PERIOD) || (m == MODE_CMPA);
    endfunction

    // Fixed period end of a fixed mode; all ones otherwise.
    function automatic logic [15:0] fixed_top(input logic [MODE_W-1:0] m);
        case (m)
            MODE_TOP8:  return 16'h00FF;
            MODE_TOP9:  return 16'h01FF;
            MODE_TOP10: return 16'h03FF;
            default:    return 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
// Register file of the PWM timer: control, period register and the
// per-channel compare buffers. Compare writes are masked to the active
// fixed resolution. Produces a one-cycle flag clear mask.
// Assumes 4 + 2*NCH <= CNT_W so all output modes fit in one word.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [CNT_W-1:0]                wr_data,
    output logic [MODE_W-1:0]               mode,
    output logic [NCH-1:0][1:0]             omode,
    output logic [CNT_W-1:0]                period,
    output logic [NCH-1:0][CNT_W-1:0]       cmp_buf,
    output logic [NCH+1:0]                  flag_clr
);

    localparam int FLAG_N = NCH + 2;

    logic [CNT_W-1:0] wr_mask;

    // Mask applied to compare writes: fixed resolution or full width.
    always_comb begin
        if (mode_fixed(mode)) wr_mask = CNT_W'(fixed_top(mode));
        else                  wr_mask = '1;
    end

    // Control register: mode and per-channel output modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= '0;
            omode <= '0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            mode <= wr_data[MODE_W-1:0];
            for (int i = 0; i < NCH; i++) begin
                omode[i] <= wr_data[MODE_W+2*i +: 2];
            end
        end
    end

    // Period register: unbuffered, takes effect on the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 period <= '0;
        else if (wr_en && wr_addr == ADDR_PERIOD)  period <= wr_data;
    end

    // Compare buffers, one per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_buf
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_CMP_BASE + ADDR_W'(g);
        // Capture a masked compare write for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)                             cmp_buf[g] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)   cmp_buf[g] <= wr_data & wr_mask;
        end
    end

    // Write-one-to-clear mask for the flags, valid in the write cycle.
    always_comb begin
        if (wr_en && wr_addr == ADDR_FLAGCLR) flag_clr = wr_data[FLAG_N-1:0];
        else                                  flag_clr = '0;
    end

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
// Up counter with mode-selected period end. Holds in unsupported modes
// and on cycles without a tick. Wraps naturally from all ones to zero.
// Assumes the channel-0 active compare value is supplied for mode 15.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [MODE_W-1:0]    mode,
    input  logic [CNT_W-1:0]     period,
    input  logic [CNT_W-1:0]     cmpa_act,
    output logic [CNT_W-1:0]     cnt,
    output logic [CNT_W-1:0]     top_val,
    output logic                 adv,
    output logic                 at_top
);

    // Select the period end for the current mode.
    always_comb begin
        case (mode)
            MODE_PERIOD: top_val = period;
            MODE_CMPA:   top_val = cmpa_act;
            default:     top_val = CNT_W'(fixed_top(mode));
        endcase
    end

    assign adv    = tick && mode_runs(mode);
    assign at_top = (cnt == top_val);

    // Count up on each advance, return to zero after the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (adv)    cnt <= at_top ? '0 : cnt + CNT_W'(1);
    end

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
// One compare channel: active compare register loaded from its buffer
// at the period end, match detection and the waveform state.
// Assumes adv and at_top come from the shared counter.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 at_top,
    input  logic [CNT_W-1:0]     cnt,
    input  logic [CNT_W-1:0]     cmp_buf,
    input  logic [1:0]           omode,
    output logic [CNT_W-1:0]     cmp_act,
    output logic                 hit,
    output logic                 pin
);

    logic wave;

    assign hit = adv && (cnt == cmp_act);

    // Copy the buffer into the active compare value at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)               cmp_act <= '0;
        else if (adv && at_top)   cmp_act <= cmp_buf;
    end

    // Waveform: set at the period end, cleared on a match; period end wins.
    always_ff @(posedge clk) begin
        if (!rst_n)               wave <= 1'b0;
        else if (adv && at_top)   wave <= 1'b1;
        else if (hit)             wave <= 1'b0;
    end

    // Drive the pin according to the output mode.
    always_comb begin
        case (out_mode_e'(omode))
            OUT_NONINV: pin = wave;
            OUT_INV:    pin = ~wave;
            default:    pin = 1'b0;
        endcase
    end

endmodule

// File: rtl/fast_pwm_timer.sv
`timescale 1ns/1ps
// Single-slope PWM timer top: register file, counter, NCH compare
// channels and the sticky flags. Flags are set by counting events and
// cleared by write-one-to-clear; a set in the same cycle wins.
// Assumes tick is a single-cycle enable from an external prescaler.
module fast_pwm_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [NCH-1:0]     pwm_o,
    output logic               ovf_flag,
    output logic               cap_flag,
    output logic [NCH-1:0]     cmp_flag
);

    localparam int FLAG_N = NCH + 2;

    logic [MODE_W-1:0]          mode;
    logic [NCH-1:0][1:0]        omode;
    logic [CNT_W-1:0]           period;
    logic [NCH-1:0][CNT_W-1:0]  cmp_buf;
    logic [NCH-1:0][CNT_W-1:0]  cmp_act;
    logic [FLAG_N-1:0]          flag_clr;
    logic [CNT_W-1:0]           top_val;
    logic                       adv;
    logic                       at_top;
    logic [NCH-1:0]             hit;

    tmr_regs #(.CNT_W(CNT_W), .NCH(NCH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mode     (mode),
        .omode    (omode),
        .period   (period),
        .cmp_buf  (cmp_buf),
        .flag_clr (flag_clr)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode),
        .period   (period),
        .cmpa_act (cmp_act[0]),
        .cnt      (cnt_o),
        .top_val  (top_val),
        .adv      (adv),
        .at_top   (at_top)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (adv),
            .at_top  (at_top),
            .cnt     (cnt_o),
            .cmp_buf (cmp_buf[g]),
            .omode   (omode[g]),
            .cmp_act (cmp_act[g]),
            .hit     (hit[g]),
            .pin     (pwm_o[g])
        );
    end

    // Period-end flag: set on wrap, cleared by bit 0 of a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_flag <= 1'b0;
        else        ovf_flag <= (ovf_flag & ~flag_clr[0]) | (adv & at_top);
    end

    // Period-register flag: set on wrap in mode 14, cleared by bit 1.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_flag <= 1'b0;
        else        cap_flag <= (cap_flag & ~flag_clr[1])
                                | (adv & at_top & (mode == MODE_PERIOD));
    end

    // Compare flags: set on channel match, cleared by bits 2 and up.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_flag <= '0;
        else        cmp_flag <= (cmp_flag & ~flag_clr[FLAG_N-1:2]) | hit;
    end

endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
// Property checker for the PWM timer, bound into every instance.
module tmr_checker #(
    parameter int CNT_W = 16,
    parameter int NCH   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [CNT_W-1:0]           cnt_o,
    input  logic                       adv,
    input  logic                       at_top,
    input  logic                       ovf_flag,
    input  logic [NCH-1:0][CNT_W-1:0]  cmp_act,
    input  logic [NCH-1:0][CNT_W-1:0]  cmp_buf,
    input  logic [NCH-1:0][1:0]        omode,
    input  logic [NCH-1:0]             pwm_o
);

    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_top) |=> (cnt_o == '0));

    assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !at_top) |=> (cnt_o == CNT_W'($past(cnt_o) + 1)));

    assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_o));

    assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_top) |=> ovf_flag);

    assert_buffer_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_top) |=> (cmp_act == $past(cmp_buf)));

    assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv && at_top) |=> $stable(cmp_act));

    assert_off_pin_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (omode[0] == 2'd0) |-> !pwm_o[0]);

endmodule

bind fast_pwm_timer tmr_checker #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cnt_o    (cnt_o),
    .adv      (adv),
    .at_top   (at_top),
    .ovf_flag (ovf_flag),
    .cmp_act  (cmp_act),
    .cmp_buf  (cmp_buf),
    .omode    (omode),
    .pwm_o    (pwm_o)
);

// File: tb/tb_fast_pwm_timer.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_fast_pwm_timer;

    localparam int CNT_W = 16;
    localparam int NCH   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic [CNT_W-1:0]  cnt_o;
    logic [NCH-1:0]    pwm_o;
    logic              ovf_flag;
    logic              cap_flag;
    logic [NCH-1:0]    cmp_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    fast_pwm_timer #(.CNT_W(CNT_W), .NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cnt_o(cnt_o), .pwm_o(pwm_o),
        .ovf_flag(ovf_flag), .cap_flag(cap_flag), .cmp_flag(cmp_flag)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
        step(4);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input logic [CNT_W-1:0] v, input string req);
        int n = 0;
        while (cnt_o !== v && n < 70000) begin
            @(negedge clk);
            n++;
        end
        check({req, " count reached"}, cnt_o, v);
    endtask

    // R13: reset state at the ports
    task automatic t_reset();
        do_reset();
        step(1);
        check("R13 count", cnt_o, 0);
        check("R13 flags", {ovf_flag, cap_flag, cmp_flag}, 0);
        check("R13 pins", pwm_o, 0);
    endtask

    // R2: tick gating
    task automatic t_gate();
        do_reset();
        wr(4'd0, 16'h0005);
        step(10);
        check("R2 no tick hold", cnt_o, 0);
        tick = 1'b1;
        step(5);
        check("R2 five ticks", cnt_o, 5);
        tick = 1'b0;
        step(3);
        check("R2 hold after tick off", cnt_o, 5);
    endtask

    // R1, R3: fixed period ends
    task automatic t_fixed();
        do_reset();
        wr(4'd0, 16'h0005);
        tick = 1'b1;
        wait_cnt(16'h00FF, "R1");
        check("R3 ovf not yet", ovf_flag, 0);
        step(1);
        check("R1 mode5 wrap", cnt_o, 0);
        check("R3 ovf set", ovf_flag, 1);
        do_reset();
        wr(4'd0, 16'h0006);
        tick = 1'b1;
        wait_cnt(16'h01FF, "R1 mode6");
        step(1);
        check("R1 mode6 wrap", cnt_o, 0);
        do_reset();
        wr(4'd0, 16'h0007);
        tick = 1'b1;
        wait_cnt(16'h03FF, "R1 mode7");
        step(1);
        check("R1 mode7 wrap", cnt_o, 0);
    endtask

    // R10, R4, R5, R6: output modes, flags and buffering
    task automatic t_pwm();
        do_reset();
        wr(4'd0, 16'h00E5);           // mode5, ch0 non-inv, ch1 inv, ch2 off
        wr(4'd4, 16'h0010);
        wr(4'd5, 16'h0010);
        tick = 1'b1;
        wait_cnt(16'h00FF, "R6");
        step(1);
        wait_cnt(16'h0005, "R5");
        wr(4'd2, 16'h001F);
        check("R5 flags cleared", {ovf_flag, cap_flag, cmp_flag}, 0);
        wait_cnt(16'h0010, "R10");
        check("R10 noninv high at match", pwm_o[0], 1);
        check("R10 inv low at match", pwm_o[1], 0);
        check("R10 off pin", pwm_o[2], 0);
        check("R4 flag not before match", cmp_flag[0], 0);
        step(1);
        check("R10 noninv low after match", pwm_o[0], 0);
        check("R10 inv high after match", pwm_o[1], 1);
        check("R4 flag after match", cmp_flag[0], 1);
        wr(4'd4, 16'h0040);           // buffered
        wait_cnt(16'h0030, "R6");
        check("R6 old value still active", pwm_o[0], 0);
        wait_cnt(16'h00FF, "R6");
        step(1);
        wait_cnt(16'h0040, "R6");
        check("R6 new value high at match", pwm_o[0], 1);
        step(1);
        check("R6 new value low after", pwm_o[0], 0);
    endtask

    // R9: masking in fixed mode
    task automatic t_mask();
        do_reset();
        wr(4'd0, 16'h0085);           // mode5, ch1 non-inv
        wr(4'd5, 16'h1234);
        tick = 1'b1;
        wait_cnt(16'h00FF, "R9");
        step(1);
        wait_cnt(16'h0034, "R9");
        check("R9 high at masked match", pwm_o[1], 1);
        step(1);
        check("R9 low after masked match", pwm_o[1], 0);
    endtask

    // R7, R3: period end from compare channel 0
    task automatic t_cmpa();
        do_reset();
        wr(4'd0, 16'h002F);
        wr(4'd4, 16'h0050);
        tick = 1'b1;
        wait_cnt(16'h0020, "R7");
        wr(4'd2, 16'h001F);
        wait_cnt(16'h0050, "R7");
        check("R3 ovf clear before end", ovf_flag, 0);
        step(1);
        check("R7 wrap at 0x50", cnt_o, 0);
        check("R3 ovf mode15", ovf_flag, 1);
        check("R3 cmp0 flag mode15", cmp_flag[0], 1);
        wait_cnt(16'h0010, "R7");
        wr(4'd4, 16'h0030);
        wait_cnt(16'h0030, "R7");
        step(1);
        check("R7 old end kept this period", cnt_o, 16'h0031);
        wait_cnt(16'h0050, "R7");
        step(1);
        wait_cnt(16'h0030, "R7");
        step(1);
        check("R7 new end next period", cnt_o, 0);
    endtask

    // R8, R11, R3: unbuffered period register
    task automatic t_period();
        do_reset();
        wr(4'd0, 16'h008E);           // mode14, ch1 non-inv
        wr(4'd1, 16'h0080);
        wr(4'd5, 16'h0090);
        tick = 1'b1;
        wait_cnt(16'h0080, "R8");
        step(1);
        check("R8 wrap at period", cnt_o, 0);
        check("R3 cap flag mode14", cap_flag, 1);
        wait_cnt(16'h0005, "R11");
        wr(4'd2, 16'h001F);
        wait_cnt(16'h0080, "R11");
        check("R11 pin high above end", pwm_o[1], 1);
        check("R11 no flag above end", cmp_flag[1], 0);
        step(1);
        wait_cnt(16'h0010, "R8");
        wr(4'd1, 16'h0040);
        wait_cnt(16'h0040, "R8");
        step(1);
        check("R8 immediate period", cnt_o, 0);
        wait_cnt(16'h0030, "R8");
        wr(4'd1, 16'h0010);
        step(3);
        check("R8 passes low period", (cnt_o > 16'h0030), 1);
        wait_cnt(16'hFFFF, "R8");
        step(1);
        check("R8 full wrap", cnt_o, 0);
        wait_cnt(16'h0010, "R8");
        step(1);
        check("R8 end after wrap", cnt_o, 0);
    endtask

    // R12: unsupported mode holds
    task automatic t_unsupported();
        do_reset();
        wr(4'd0, 16'h0003);
        tick = 1'b1;
        step(20);
        check("R12 count holds", cnt_o, 0);
        check("R12 no flags", {ovf_flag, cap_flag, cmp_flag}, 0);
        tick = 1'b0;
    endtask

    initial begin
        t_reset();
        t_gate();
        t_fixed();
        t_pwm();
        t_mask();
        t_cmpa();
        t_period();
        t_unsupported();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule